// File: doc/BRIEF.md
# Compare-Match Timer Bank

A bank of independent up-counting timer channels sits behind a single-cycle register port: an address, write data and a write strobe, with combinational read data. Each channel has a control word, a tick-select word, a read-only count and a compare value. A channel can run once, repeat, or run free. Two tick-enable inputs share the block's clock: a fast system tick and a slow real-time tick. Each channel chooses one of them and can halve its rate.

Compare events from every channel set flags in a shared pending register. A shared enable register masks these flags, and their OR drives one interrupt line. Software clears a flag by writing 1 to its bit.

Top module: `cmp_timer_bank`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low. Every channel is therefore disabled, in one-shot mode, on the fast tick, with no prescale.
- R2: Byte address 0x00 is the interrupt enable register and 0x08 is the pending register (reads return the flags, writes acknowledge). Channel n (1..N_CH) owns bit n-1 in both registers and the block at 0x10*n, laid out as control +0x0, tick select +0x4, count +0x8 and compare +0xC. The count is read-only, so writes to it have no effect. Unmapped addresses read zero.
- R3: Control bit 0 is the enable. Bits [5:4] hold the mode: 0 one-shot, 1 repeat, 3 free-run, and 2 acts as one-shot. Bit 1 is a clear strobe: writing 1 zeroes the count and the prescale phase at that write, and the bit always reads back 0.
- R4: Tick-select bit 4 chooses the slow tick (1) or the fast tick (0). Bit 0 = 1 divides the chosen tick by two. An enabled channel adds one to its count on each prescaled tick. With the divide on, the channel never advances on two cycles in a row.
- R5: In repeat mode, an advance tick that finds count equal to compare sets the channel's pending bit and restarts the count at 0.
- R6: In one-shot mode the same event sets the pending bit, clears the enable bit and holds the count.
- R7: In free-run mode the compare value is ignored, the count wraps from all ones to 0, and no pending bit is ever set.
- R8: `irq_o` is high exactly while some pending bit is set whose enable bit is set.
- R9: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. Writing 0x3F clears all six flags at once.
- R10: When a compare event and an acknowledge for the same channel fall in the same cycle, the pending bit stays set.
- R11: A control write takes precedence over counting in its cycle: that cycle the channel neither advances nor matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the register access |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| fast_tick_i | input | 1 | Fast system tick enable |
| slow_tick_i | input | 1 | Slow real-time tick enable |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the bank with six channels and a counter width of 8 bits, keeping the 32-bit register layout. At that width a free-running channel wraps after 256 ticks, so the all-ones-to-zero roll-over and the silence of its compare logic are checked directly. Six channels fill the acknowledge mask, so a write of 0x3F covers the whole bank. A seeded random phase then mixes writes to every register with both tick sources against a bench model of the bank.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_ONCE   = 2'd0,
    MODE_REPEAT = 2'd1,
    MODE_RSVD   = 2'd2,
    MODE_FREE   = 2'd3
  } tmr_mode_e;

  // word offsets inside a 16-byte block (addr[3:2])
  localparam logic [1:0] OFF_IEN  = 2'd0;
  localparam logic [1:0] OFF_PEND = 2'd2;
  localparam logic [1:0] OFF_CTRL = 2'd0;
  localparam logic [1:0] OFF_TSEL = 2'd1;
  localparam logic [1:0] OFF_CNT  = 2'd2;
  localparam logic [1:0] OFF_CMP  = 2'd3;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CLR_BIT  = 1;
  localparam int CTRL_MODE_LSB = 4;
  localparam int TSEL_DIV_BIT  = 0;
  localparam int TSEL_SRC_BIT  = 4;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_tick_i,
  input  logic slow_tick_i,
  input  logic src_i,
  input  logic div2_i,
  input  logic run_i,
  input  logic clr_i,
  output logic adv_o
);
  logic ph_q;
  logic tick;

  assign tick  = src_i ? slow_tick_i : fast_tick_i;
  assign adv_o = run_i & tick & (~div2_i | ph_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ph_q <= 1'b0;
    else if (clr_i)                   ph_q <= 1'b0;
    else if (run_i && tick && div2_i) ph_q <= ~ph_q;
  end

  // R4
  div2_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && div2_i) |=> !(adv_o && div2_i));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pkg::*; #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              tsel_we_i,
  input  logic              cmp_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fast_tick_i,
  input  logic              slow_tick_i,
  output logic [DATA_W-1:0] ctrl_rd_o,
  output logic [DATA_W-1:0] tsel_rd_o,
  output logic [DATA_W-1:0] cnt_rd_o,
  output logic [DATA_W-1:0] cmp_rd_o,
  output logic              match_o
);
  logic             en_q, src_q, div_q;
  tmr_mode_e        mode_q;
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             adv, clr;

  assign clr = ctrl_we_i & wdata_i[CTRL_CLR_BIT];

  tmr_tick_sel u_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fast_tick_i (fast_tick_i),
    .slow_tick_i (slow_tick_i),
    .src_i       (src_q),
    .div2_i      (div_q),
    .run_i       (en_q & ~ctrl_we_i),
    .clr_i       (clr),
    .adv_o       (adv)
  );

  assign match_o = adv & (mode_q != MODE_FREE) & (cnt_q == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= MODE_ONCE;
      cnt_q  <= '0;
    end else if (ctrl_we_i) begin
      en_q   <= wdata_i[CTRL_EN_BIT];
      mode_q <= tmr_mode_e'(wdata_i[CTRL_MODE_LSB +: 2]);
      if (clr) cnt_q <= '0;
    end else if (match_o) begin
      if (mode_q == MODE_REPEAT) cnt_q <= '0;
      else                       en_q  <= 1'b0;
    end else if (adv) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= 1'b0;
      div_q <= 1'b0;
      cmp_q <= '0;
    end else begin
      if (tsel_we_i) begin
        src_q <= wdata_i[TSEL_SRC_BIT];
        div_q <= wdata_i[TSEL_DIV_BIT];
      end
      if (cmp_we_i) cmp_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    ctrl_rd_o = '0;
    ctrl_rd_o[CTRL_EN_BIT] = en_q;
    ctrl_rd_o[CTRL_MODE_LSB +: 2] = mode_q;
    tsel_rd_o = '0;
    tsel_rd_o[TSEL_SRC_BIT] = src_q;
    tsel_rd_o[TSEL_DIV_BIT] = div_q;
  end
  assign cnt_rd_o = DATA_W'(cnt_q);
  assign cmp_rd_o = DATA_W'(cmp_q);

  // R3
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> cnt_q == '0);
  // R5
  rpt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && mode_q == MODE_REPEAT && !ctrl_we_i) |=> (cnt_q == '0 && en_q));
  // R6
  once_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && mode_q != MODE_REPEAT && !ctrl_we_i) |=> (!en_q && $stable(cnt_q)));
  // R7
  free_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode_q == MODE_FREE && !ctrl_we_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R11
  wr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> en_q == $past(wdata_i[CTRL_EN_BIT]));
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int N_CH = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ien_we_i,
  input  logic            ack_we_i,
  input  logic [N_CH-1:0] wdata_i,
  input  logic [N_CH-1:0] match_i,
  output logic [N_CH-1:0] ien_o,
  output logic [N_CH-1:0] pend_o,
  output logic            irq_o
);
  logic [N_CH-1:0] ien_q, pend_q, ack_mask;

  assign ack_mask = ack_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= '0;
      pend_q <= '0;
    end else begin
      if (ien_we_i) ien_q <= wdata_i;
      pend_q <= match_i | (pend_q & ~ack_mask);  // new event beats ack
    end
  end

  assign ien_o  = ien_q;
  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & ien_q);

  // R10
  hit_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|match_i) |=> ((pend_q & $past(match_i)) == $past(match_i)));
  // R9
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_we_i |=> ((pend_q & $past(wdata_i & ~match_i)) == '0));
  // R9
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_we_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/cmp_timer_bank.sv
module cmp_timer_bank import tmr_pkg::*; #(
  parameter int N_CH   = 6,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              fast_tick_i,
  input  logic              slow_tick_i,
  output logic              irq_o
);
  localparam int BLK_W = ADDR_W - 4;

  logic [BLK_W-1:0] blk;
  logic [1:0]       off;
  logic [N_CH-1:0]  match, ien, pend;
  logic [DATA_W-1:0] ctrl_rd [N_CH];
  logic [DATA_W-1:0] tsel_rd [N_CH];
  logic [DATA_W-1:0] cnt_rd  [N_CH];
  logic [DATA_W-1:0] cmp_rd  [N_CH];

  assign blk = addr_i[ADDR_W-1:4];
  assign off = addr_i[3:2];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic sel;
    assign sel = we_i && (blk == BLK_W'(c + 1));

    tmr_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ctrl_we_i   (sel && off == OFF_CTRL),
      .tsel_we_i   (sel && off == OFF_TSEL),
      .cmp_we_i    (sel && off == OFF_CMP),
      .wdata_i     (wdata_i),
      .fast_tick_i (fast_tick_i),
      .slow_tick_i (slow_tick_i),
      .ctrl_rd_o   (ctrl_rd[c]),
      .tsel_rd_o   (tsel_rd[c]),
      .cnt_rd_o    (cnt_rd[c]),
      .cmp_rd_o    (cmp_rd[c]),
      .match_o     (match[c])
    );
  end

  tmr_irq_ctrl #(.N_CH(N_CH)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ien_we_i (we_i && blk == '0 && off == OFF_IEN),
    .ack_we_i (we_i && blk == '0 && off == OFF_PEND),
    .wdata_i  (wdata_i[N_CH-1:0]),
    .match_i  (match),
    .ien_o    (ien),
    .pend_o   (pend),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (blk == '0) begin
      case (off)
        OFF_IEN:  rdata_o = DATA_W'(ien);
        OFF_PEND: rdata_o = DATA_W'(pend);
        default:  rdata_o = '0;
      endcase
    end
    for (int c = 0; c < N_CH; c++) begin
      if (blk == BLK_W'(c + 1)) begin
        case (off)
          OFF_CTRL: rdata_o = ctrl_rd[c];
          OFF_TSEL: rdata_o = tsel_rd[c];
          OFF_CNT:  rdata_o = cnt_rd[c];
          default:  rdata_o = cmp_rd[c];
        endcase
      end
    end
  end

  // R8
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |-> !irq_o);
endmodule

// File: tb/cmp_timer_bank_bench.sv
module cmp_timer_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;
  localparam int CW = 8;
  localparam logic [31:0] MASK = 32'h0000_00FF;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [7:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic we_i = 1'b0, fast = 1'b0, slow = 1'b0;
  logic [31:0] rdata_o;
  logic irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_cnt [N];
  logic [31:0] m_cmp [N];
  logic        m_en [N];
  logic        m_src [N];
  logic        m_div [N];
  logic        m_ph [N];
  logic [1:0]  m_mode [N];
  logic [5:0]  m_pend = '0, m_ien = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer_bank #(.N_CH(N), .CNT_W(CW), .ADDR_W(8), .DATA_W(32)) u_cmp_timer_bank (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i),
    .rdata_o(rdata_o), .fast_tick_i(fast), .slow_tick_i(slow), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int b = int'(a[7:4]);
    int o = int'(a[3:2]);
    if (b == 0) return (o == 0) ? {26'd0, m_ien} : (o == 2) ? {26'd0, m_pend} : 32'd0;
    if (b > N) return 32'd0;
    case (o)
      0: return {26'd0, m_mode[b-1], 3'd0, m_en[b-1]};
      1: return {27'd0, m_src[b-1], 3'd0, m_div[b-1]};
      2: return m_cnt[b-1];
      default: return m_cmp[b-1];
    endcase
  endfunction

  task automatic model_step(input logic w, input logic [7:0] a, input logic [31:0] d,
                            input logic f, input logic s);
    int b = int'(a[7:4]);
    int o = int'(a[3:2]);
    logic [5:0] hit = '0;
    logic [5:0] ackm;
    for (int i = 0; i < N; i++) begin
      logic t, adv;
      if (w && b == i + 1 && o == 0) begin
        m_en[i] = d[0];
        m_mode[i] = d[5:4];
        if (d[1]) begin m_cnt[i] = 0; m_ph[i] = 0; end
      end else if (m_en[i]) begin
        t = m_src[i] ? s : f;
        adv = 0;
        if (t) begin
          if (m_div[i]) begin adv = m_ph[i]; m_ph[i] = ~m_ph[i]; end
          else adv = 1;
        end
        if (adv) begin
          if (m_mode[i] != 2'd3 && m_cnt[i] == m_cmp[i]) begin
            hit[i] = 1;
            if (m_mode[i] == 2'd1) m_cnt[i] = 0;
            else m_en[i] = 0;
          end else m_cnt[i] = (m_cnt[i] + 1) & MASK;
        end
      end
      if (w && b == i + 1 && o == 1) begin m_src[i] = d[4]; m_div[i] = d[0]; end
      if (w && b == i + 1 && o == 3) m_cmp[i] = d & MASK;
    end
    ackm = (w && b == 0 && o == 2) ? d[5:0] : 6'd0;
    m_pend = hit | (m_pend & ~ackm);
    if (w && b == 0 && o == 0) m_ien = d[5:0];
  endtask

  // starts and ends just after a falling edge
  task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic f, input logic s);
    we_i = w; addr_i = a; wdata_i = d; fast = f; slow = s;
    model_step(w, a, d, f, s);
    @(posedge clk); @(negedge clk);
    we_i = 0; fast = 0; slow = 0;
    chk("R8 irq", {31'd0, irq_o}, {31'd0, |(m_pend & m_ien)});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic run(input int n, input logic f, input logic s);
    for (int k = 0; k < n; k++) cyc(1'b0, 8'h00, 32'd0, f, s);
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    we_i = 0; fast = 0; slow = 0; addr_i = a;
    #1 chk(tag, rdata_o, m_read(a));
    model_step(1'b0, a, 32'd0, 1'b0, 1'b0);
    @(negedge clk);
  endtask

  task automatic rd_all(input string tag);
    rd_chk(8'h00, tag);
    rd_chk(8'h08, tag);
    for (int c = 1; c <= N; c++)
      for (int o = 0; o < 4; o++) rd_chk(8'((c << 4) | (o << 2)), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_val;
    seed_val = $urandom(32'd4242);
    for (int i = 0; i < N; i++) begin
      m_cnt[i] = 0; m_cmp[i] = 0; m_en[i] = 0; m_src[i] = 0;
      m_div[i] = 0; m_ph[i] = 0; m_mode[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    rd_all("R1");
    rd_chk(8'h7C, "R2 unmapped");

    // R5 repeat on ch1, cmp 3, irq enabled
    wr(8'h00, 32'h01);
    wr(8'h1C, 32'd3);
    wr(8'h10, 32'h13);
    run(3, 1, 0);
    rd_chk(8'h18, "R5 count before match");
    run(2, 1, 0);
    rd_chk(8'h08, "R5 pending");
    rd_chk(8'h18, "R5 restart");
    chk("R8 irq high", {31'd0, irq_o}, 32'd1);
    run(7, 1, 0);
    rd_chk(8'h18, "R5 second period");

    // R9 ack semantics
    wr(8'h10, 32'h10);
    wr(8'h08, 32'h00);
    rd_chk(8'h08, "R9 zero ack keeps");
    wr(8'h08, 32'h01);
    rd_chk(8'h08, "R9 one ack clears");

    // R6 one-shot on ch2, irq masked
    wr(8'h2C, 32'd2);
    wr(8'h20, 32'h03);
    run(8, 1, 0);
    rd_chk(8'h20, "R6 enable dropped");
    rd_chk(8'h28, "R6 count held");
    rd_chk(8'h08, "R6 pending");
    chk("R8 masked", {31'd0, irq_o}, 32'd0);

    // R7 free-run wrap on ch3
    wr(8'h3C, 32'd5);
    wr(8'h30, 32'h33);
    run(300, 1, 0);
    rd_chk(8'h38, "R7 wrapped count");
    rd_chk(8'h08, "R7 no pending");

    // R4 slow tick, divide by 2 on ch4
    wr(8'h44, 32'h11);
    rd_chk(8'h44, "R4 tick select");
    wr(8'h40, 32'h33);
    for (int k = 0; k < 40; k++) cyc(1'b0, 8'h00, 32'd0, 1'b1, (k % 3) == 0);
    rd_chk(8'h48, "R4 prescaled count");
    for (int k = 0; k < 20; k++) cyc(1'b0, 8'h00, 32'd0, 1'b0, 1'b1);
    rd_chk(8'h48, "R4 slow every cycle");

    // R3 clear strobe
    wr(8'h40, 32'h33);
    rd_chk(8'h48, "R3 cleared");
    rd_chk(8'h40, "R3 clear reads zero");

    // R11 control write beats tick
    wr(8'h50, 32'h33);
    run(4, 1, 0);
    cyc(1'b1, 8'h50, 32'h31, 1'b1, 1'b0);
    rd_chk(8'h58, "R11 no advance on write");

    // R10 match and ack together on ch6 (cmp 0, every tick matches)
    wr(8'h00, 32'h21);
    wr(8'h60, 32'h13);
    for (int k = 0; k < 4; k++) cyc(1'b1, 8'h08, 32'h20, 1'b1, 1'b0);
    rd_chk(8'h08, "R10 pending kept");

    // R2 count write ignored
    cyc(1'b1, 8'h68, 32'hAA, 1'b0, 1'b0);
    rd_chk(8'h68, "R2 count read-only");

    // R9 clear all
    for (int c = 1; c <= N; c++) wr(8'(c << 4), 32'h0);
    wr(8'h08, 32'h3F);
    rd_chk(8'h08, "R9 ack all");

    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic w;
      logic [3:0] b;
      logic [1:0] o;
      logic [31:0] d;
      w = ($urandom % 4) == 0;
      b = 4'($urandom % 7);
      o = 2'($urandom % 4);
      d = $urandom;
      if (b != 0 && o == 0) d = (d & 32'h33) | (($urandom % 3 != 0) ? 32'h1 : 32'h0);
      if (b != 0 && o == 3) d = $urandom % 24;
      cyc(w, {b, o, 2'b00}, d, 1'($urandom % 2), ($urandom % 5) == 0);
      if ((k % 16) == 15) rd_all("R2 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule